// File: doc/BRIEF.md
# Element-Width Overlay Register File

This block is a file of 64-bit registers whose storage also serves as one contiguous byte array. A vector operand is described by a base register, an element index and an element width of 8, 16, 32 or 64 bits. Elements are packed in little-endian order, so element 0 of any width sits at the least significant end of the base register. Later elements fill that register upward and then continue into the next register.

Each of the eight byte lanes is a separate narrow storage bank with its own write enable. The element write port turns its addressing into a register number, a starting lane and a byte-enable mask. Lane k always holds bits 8k+7:8k, and no reversed lane arithmetic is used for any width. The element read port uses the same addressing and returns the element zero-extended to 64 bits. A separate scalar port reads and writes whole 64-bit registers.

Top module: `ewreg_file`

## Requirements
- R1: A synchronous active-high reset clears every register to zero.
- R2: A scalar write (`sc_wr_en`) stores all 64 bits of `sc_wr_data` into register `sc_wr_addr` at the rising edge, with all eight byte enables asserted. `sc_rd_data` shows register `sc_rd_addr` combinationally.
- R3: Width code 00 selects 64-bit elements, 01 selects 32-bit, 10 selects 16-bit and 11 selects 8-bit. Byte offset = index × element bytes. Register = base + offset/8. Starting lane = offset mod 8.
- R4: An element write changes only the bytes of its element. Byte lane k (bits 8k+7:8k) is enabled exactly when the element covers offset k of the register, so 1, 2, 4 or 8 lanes are enabled.
- R5: An element read returns the element in the low bits of `rd_data`, with all higher bits zero.
- R6: Element index 0 of any width addresses the least significant end of the base register, the same bits a scalar view of that width would see.
- R7: Elements run through consecutive registers. Once the eight bytes of a register are used, the next element starts at lane 0 of the following register.
- R8: An element write whose register number is 32 or more raises `wr_oor` in the same cycle and changes no storage.
- R9: An element read whose register number is 32 or more returns zero.
- R10: A read of a register being written in the same cycle returns the contents from before the write.
- R11: When a scalar write and an element write are requested in the same cycle, only the scalar write is performed.
- R12: Start with register 0 holding all ones. Writing 0x55 to byte element 1 of base 0 makes 32-bit element 0 of base 0 read 0xFFFF55FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Element write request |
| wr_base | input | 5 | Element write base register |
| wr_idx | input | 6 | Element write index |
| wr_wcode | input | 2 | Element write width code |
| wr_data | input | 64 | Element write data, right-aligned |
| wr_oor | output | 1 | Element write target beyond the last register |
| rd_base | input | 5 | Element read base register |
| rd_idx | input | 6 | Element read index |
| rd_wcode | input | 2 | Element read width code |
| rd_data | output | 64 | Zero-extended element read data |
| sc_wr_en | input | 1 | Scalar write request |
| sc_wr_addr | input | 5 | Scalar write register |
| sc_wr_data | input | 64 | Scalar write data |
| sc_rd_addr | input | 5 | Scalar read register |
| sc_rd_data | output | 64 | Scalar read data |

## Verification
Both read ports and `wr_oor` are combinational, so they are due in the same cycle that their inputs are applied. A write shows up on the read ports only after the next rising edge. The bench changes inputs just after a falling edge and compares the combinational outputs 1 ns later, before the rising edge. That timing is also what lets the read-during-write case observe the old contents. Results of a write are checked only once the rising edge has passed. Expected values come from a byte-level model in the bench that applies the offset arithmetic of R3.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;

  typedef enum logic [1:0] {
    EW_D64 = 2'b00,
    EW_W32 = 2'b01,
    EW_H16 = 2'b10,
    EW_B8  = 2'b11
  } ew_code_e;

  // log2 of the element size in bytes
  function automatic logic [1:0] ew_log2_bytes(input ew_code_e c);
    return 2'd3 - c;
  endfunction

  // byte mask of one element, anchored at lane 0
  function automatic logic [7:0] ew_size_mask(input ew_code_e c);
    case (c)
      EW_D64:  return 8'hFF;
      EW_W32:  return 8'h0F;
      EW_H16:  return 8'h03;
      default: return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/ewrf_addr_gen.sv
module ewrf_addr_gen
  import ewrf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDX_W = 6,
  parameter int REG_W = $clog2(NREGS)
) (
  input  logic [REG_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       wcode,
  output logic [REG_W-1:0] reg_num,
  output logic [2:0]       lane,
  output logic [7:0]       byte_mask,
  output logic             oor
);
  localparam int SUM_W = ((IDX_W > REG_W) ? IDX_W : REG_W) + 1;
  localparam int OFF_W = IDX_W + 3;

  logic [OFF_W-1:0] offset;
  logic [SUM_W-1:0] sum;

  always_comb begin
    offset    = {3'b000, idx} << ew_log2_bytes(ew_code_e'(wcode));
    sum       = SUM_W'(base) + SUM_W'(offset[OFF_W-1:3]);
    oor       = (sum >= SUM_W'(NREGS));
    reg_num   = sum[REG_W-1:0];
    lane      = offset[2:0];
    byte_mask = ew_size_mask(ew_code_e'(wcode)) << lane;
  end

endmodule

// File: rtl/ewrf_lane_bank.sv
module ewrf_lane_bank #(
  parameter int NREGS = 32,
  parameter int REG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [REG_W-1:0] raddr_a,
  input  logic [REG_W-1:0] raddr_b,
  output logic [7:0]       rdata_a,
  output logic [7:0]       rdata_b
);
  logic [7:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ewrf_read_align.sv
module ewrf_read_align (
  input  logic [63:0] word,
  input  logic [2:0]  lane,
  input  logic [7:0]  byte_mask,
  input  logic        oor,
  output logic [63:0] elem
);
  logic [63:0] shifted;
  logic [7:0]  low_mask;
  logic [63:0] bit_mask;

  always_comb begin
    shifted  = word >> {lane, 3'b000};
    low_mask = byte_mask >> lane;
    for (int j = 0; j < 8; j++) bit_mask[8*j +: 8] = {8{low_mask[j]}};
    elem = oor ? 64'd0 : (shifted & bit_mask);
  end

endmodule

// File: rtl/ewreg_file.sv
module ewreg_file #(
  parameter int NREGS = 32,
  parameter int IDX_W = 6,
  parameter int REG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_base,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_wcode,
  input  logic [63:0]      wr_data,
  output logic             wr_oor,
  input  logic [REG_W-1:0] rd_base,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_wcode,
  output logic [63:0]      rd_data,
  input  logic             sc_wr_en,
  input  logic [REG_W-1:0] sc_wr_addr,
  input  logic [63:0]      sc_wr_data,
  input  logic [REG_W-1:0] sc_rd_addr,
  output logic [63:0]      sc_rd_data
);
  localparam int NLANES = 8;

  logic [REG_W-1:0] w_reg, r_reg;
  logic [2:0]       w_lane, r_lane;
  logic [7:0]       w_mask, r_mask;
  logic             w_oor, r_oor;

  ewrf_addr_gen #(.NREGS(NREGS), .IDX_W(IDX_W), .REG_W(REG_W)) wgen_i (
    .base(wr_base), .idx(wr_idx), .wcode(wr_wcode),
    .reg_num(w_reg), .lane(w_lane), .byte_mask(w_mask), .oor(w_oor)
  );

  ewrf_addr_gen #(.NREGS(NREGS), .IDX_W(IDX_W), .REG_W(REG_W)) rgen_i (
    .base(rd_base), .idx(rd_idx), .wcode(rd_wcode),
    .reg_num(r_reg), .lane(r_lane), .byte_mask(r_mask), .oor(r_oor)
  );

  logic             ew_fire;
  logic [63:0]      ew_shifted;
  logic [NLANES-1:0] lane_we;
  logic [REG_W-1:0] lane_wa;
  logic [63:0]      lane_wd;
  logic [63:0]      elem_word;

  assign wr_oor     = wr_en & w_oor;
  assign ew_fire    = wr_en & ~w_oor & ~sc_wr_en;
  assign ew_shifted = wr_data << {w_lane, 3'b000};
  assign lane_wa    = sc_wr_en ? sc_wr_addr : w_reg;
  assign lane_wd    = sc_wr_en ? sc_wr_data : ew_shifted;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign lane_we[k] = sc_wr_en | (ew_fire & w_mask[k]);

    ewrf_lane_bank #(.NREGS(NREGS), .REG_W(REG_W)) bank_i (
      .clk(clk), .rst(rst),
      .we(lane_we[k]), .waddr(lane_wa), .wdata(lane_wd[8*k +: 8]),
      .raddr_a(r_reg), .raddr_b(sc_rd_addr),
      .rdata_a(elem_word[8*k +: 8]), .rdata_b(sc_rd_data[8*k +: 8])
    );
  end

  ewrf_read_align align_i (
    .word(elem_word), .lane(r_lane), .byte_mask(r_mask), .oor(r_oor),
    .elem(rd_data)
  );

endmodule

// File: rtl/ewrf_checker.sv
module ewrf_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_oor,
  input logic [1:0]       rd_wcode,
  input logic [63:0]      rd_data,
  input logic             r_oor,
  input logic             sc_wr_en,
  input logic [REG_W-1:0] sc_wr_addr,
  input logic [63:0]      sc_wr_data,
  input logic [REG_W-1:0] sc_rd_addr,
  input logic [63:0]      sc_rd_data,
  input logic [7:0]       lane_we
);
  logic past_live;
  always_ff @(posedge clk) past_live <= ~rst;

  assert_scalar_all_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    sc_wr_en |-> (lane_we == 8'hFF));

  assert_scalar_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (past_live && $past(sc_wr_en) && (sc_rd_addr == $past(sc_wr_addr)))
      |-> (sc_rd_data == $past(sc_wr_data)));

  assert_no_oor_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_oor && !sc_wr_en) |-> (lane_we == 8'h00));

  assert_lane_count_R4: assert property (@(posedge clk) disable iff (rst)
    !sc_wr_en |-> ($countones(lane_we) == 0 || $countones(lane_we) == 1 ||
                   $countones(lane_we) == 2 || $countones(lane_we) == 4 ||
                   $countones(lane_we) == 8));

  assert_byte_zero_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_wcode == 2'b11) |-> (rd_data[63:8] == 56'd0));

  assert_oor_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    r_oor |-> (rd_data == 64'd0));

endmodule

bind ewreg_file ewrf_checker #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .wr_oor(wr_oor), .rd_wcode(rd_wcode), .rd_data(rd_data),
  .r_oor(r_oor), .sc_wr_en(sc_wr_en), .sc_wr_addr(sc_wr_addr),
  .sc_wr_data(sc_wr_data), .sc_rd_addr(sc_rd_addr), .sc_rd_data(sc_rd_data),
  .lane_we(lane_we)
);

// File: tb/ewreg_file_tb_top.sv
`timescale 1ns/1ps
module ewreg_file_tb_top;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst;
  logic        wr_en, sc_wr_en;
  logic [4:0]  wr_base, rd_base, sc_wr_addr, sc_rd_addr;
  logic [5:0]  wr_idx, rd_idx;
  logic [1:0]  wr_wcode, rd_wcode;
  logic [63:0] wr_data, sc_wr_data;
  logic        wr_oor;
  logic [63:0] rd_data, sc_rd_data;

  ewreg_file dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
    .wr_wcode(wr_wcode), .wr_data(wr_data), .wr_oor(wr_oor),
    .rd_base(rd_base), .rd_idx(rd_idx), .rd_wcode(rd_wcode), .rd_data(rd_data),
    .sc_wr_en(sc_wr_en), .sc_wr_addr(sc_wr_addr), .sc_wr_data(sc_wr_data),
    .sc_rd_addr(sc_rd_addr), .sc_rd_data(sc_rd_data)
  );

  int checks = 0, errors = 0;
  logic [63:0] model [32];
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] wc);
    return 1 << (3 - int'(wc));
  endfunction

  function automatic int tgt_reg(input logic [4:0] b, input logic [5:0] i, input logic [1:0] wc);
    return int'(b) + (int'(i) * nbytes(wc)) / 8;
  endfunction

  function automatic logic [63:0] exp_read(input logic [4:0] b, input logic [5:0] i, input logic [1:0] wc);
    int off = int'(i) * nbytes(wc);
    int r = int'(b) + off / 8;
    logic [63:0] v = 0;
    if (r >= 32) return 64'd0;
    for (int k = 0; k < nbytes(wc); k++) v[8*k +: 8] = model[r][8*((off % 8) + k) +: 8];
    return v;
  endfunction

  task automatic model_write(input logic [4:0] b, input logic [5:0] i, input logic [1:0] wc, input logic [63:0] d);
    int off = int'(i) * nbytes(wc);
    int r = int'(b) + off / 8;
    if (r < 32)
      for (int k = 0; k < nbytes(wc); k++) model[r][8*((off % 8) + k) +: 8] = d[8*k +: 8];
  endtask

  // element write; checks the range flag in the cycle it is applied
  task automatic el_write(input logic [4:0] b, input logic [5:0] i, input logic [1:0] wc,
                          input logic [63:0] d, input string tag);
    @(negedge clk);
    wr_en = 1; wr_base = b; wr_idx = i; wr_wcode = wc; wr_data = d;
    #1 check({tag, " R8 flag"}, {63'd0, wr_oor}, {63'd0, tgt_reg(b, i, wc) >= 32});
    @(posedge clk); #1 wr_en = 0;
    model_write(b, i, wc, d);
  endtask

  task automatic sc_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    sc_wr_en = 1; sc_wr_addr = a; sc_wr_data = d;
    @(posedge clk); #1 sc_wr_en = 0;
    model[a] = d;
  endtask

  task automatic el_check(input logic [4:0] b, input logic [5:0] i, input logic [1:0] wc, input string tag);
    @(negedge clk);
    rd_base = b; rd_idx = i; rd_wcode = wc;
    #1 check(tag, rd_data, exp_read(b, i, wc));
  endtask

  task automatic sc_check(input logic [4:0] a, input string tag);
    @(negedge clk);
    sc_rd_addr = a;
    #1 check(tag, sc_rd_data, model[a]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; wr_en = 0; sc_wr_en = 0;
    wr_base = 0; wr_idx = 0; wr_wcode = 0; wr_data = 0;
    rd_base = 0; rd_idx = 0; rd_wcode = 0;
    sc_wr_addr = 0; sc_wr_data = 0; sc_rd_addr = 0;
    for (int r = 0; r < 32; r++) model[r] = 64'hDEAD_BEEF_0BAD_F00D;
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      sc_wr_en = 1; sc_wr_addr = 5'(r); sc_wr_data = 64'hDEAD_BEEF_0BAD_F00D;
    end
    @(negedge clk); sc_wr_en = 0; rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    for (int r = 0; r < 32; r++) model[r] = 0;
    for (int r = 0; r < 32; r++) sc_check(5'(r), "R1 reset clear");

    // R2 scalar path
    sc_write(5'd3, 64'h0123_4567_89AB_CDEF);
    sc_check(5'd3, "R2 scalar write");

    // R12 / R4 example
    sc_write(5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    el_write(5'd0, 6'd1, 2'b11, 64'h55, "R12");
    el_check(5'd0, 6'd0, 2'b01, "R12 word view");
    check("R12 literal", rd_data, 64'h0000_0000_FFFF_55FF);
    sc_check(5'd0, "R4 only element bytes");

    // R6 index 0 equals low end
    el_check(5'd3, 6'd0, 2'b10, "R6 half idx0");
    check("R6 literal", rd_data, 64'h0000_0000_0000_CDEF);
    el_check(5'd3, 6'd0, 2'b00, "R6 dword idx0");

    // R3 / R7 sequential run
    el_write(5'd4, 6'd9, 2'b11, 64'hA7, "R7 byte");
    sc_check(5'd5, "R7 byte lands reg5 lane1");
    check("R7 literal", sc_rd_data, 64'h0000_0000_0000_A700);
    el_write(5'd6, 6'd4, 2'b10, 64'hBEEF, "R3 half");
    sc_check(5'd7, "R3 half reg7 lane0");
    el_write(5'd8, 6'd3, 2'b01, 64'hCAFE_F00D, "R3 word");
    sc_check(5'd9, "R3 word reg9 lane4");
    el_write(5'd2, 6'd1, 2'b00, 64'h1111_2222_3333_4444, "R3 dword");
    sc_check(5'd3, "R3 dword reg3");

    // R8 out of range write
    sc_write(5'd31, 64'h3131_3131_3131_3131);
    el_write(5'd31, 6'd8, 2'b11, 64'h99, "R8 oor");
    sc_check(5'd31, "R8 reg31 untouched");
    sc_check(5'd0, "R8 no wraparound");

    // R9 out of range read
    el_check(5'd30, 6'd2, 2'b00, "R9 oor read zero");
    check("R9 literal", rd_data, 64'd0);

    // R10 read during write
    @(negedge clk);
    wr_en = 1; wr_base = 5'd5; wr_idx = 6'd0; wr_wcode = 2'b00; wr_data = 64'h7777;
    rd_base = 5'd5; rd_idx = 6'd0; rd_wcode = 2'b00; sc_rd_addr = 5'd5;
    #1 check("R10 elem old", rd_data, model[5]);
    check("R10 scalar old", sc_rd_data, model[5]);
    @(posedge clk); #1 wr_en = 0; model[5] = 64'h7777;
    sc_check(5'd5, "R10 new after edge");

    // R11 scalar priority
    @(negedge clk);
    wr_en = 1; wr_base = 5'd12; wr_idx = 6'd0; wr_wcode = 2'b00; wr_data = 64'hBAD;
    sc_wr_en = 1; sc_wr_addr = 5'd10; sc_wr_data = 64'hC0DE;
    @(posedge clk); #1 wr_en = 0; sc_wr_en = 0; model[10] = 64'hC0DE;
    sc_check(5'd12, "R11 element dropped");
    sc_check(5'd10, "R11 scalar done");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] b = 5'($urandom_range(0, 31));
      logic [5:0] i = 6'($urandom_range(0, 63));
      logic [1:0] wc = 2'($urandom_range(0, 3));
      logic [63:0] d = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: sc_write(b, d);
        1, 2: el_write(b, i, wc, d, "R3 rand write");
        default: ;
      endcase
      el_check(5'($urandom_range(0, 31)), 6'($urandom_range(0, 63)), 2'($urandom_range(0, 3)), "R5 rand read");
    end
    for (int r = 0; r < 32; r++) sc_check(5'(r), "R4 final sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule